// File: doc/BRIEF.md
# Multi-Lane State Shift Register

This block is the input stage of a neuron arithmetic unit. It holds a row of small neuron states, each three bits wide, in a register that shifts to the left. A shift command carries a count from zero to four. The register moves its contents left by that many slots, and the freed slots at the right end are filled from a 12-bit input word that packs four states. Any state pushed past the left end is lost.

A store command copies the whole register as one vector. The copy can go into a small on-chip state memory at a given address, into the input latches of the arithmetic unit, or into both at once. The latches change only when a store selects them. The arithmetic unit can therefore keep computing on a stable operand while new states are being shifted in during the same cycles. A store and a shift may be issued together. In that case the store takes the contents the register had before the shift.

Top module: `lane_shift_stage`

## Requirements
- R1: A synchronous active-low reset clears every register slot and every latch slot to zero.
- R2: A shift with count n in 1..4 moves each slot n positions toward the left end (slot k goes to slot k+n). The n states in the top slots are discarded. Slot 0 is bits [2:0] of the register and slot 63 is bits [191:189].
- R3: State lane i of the input word is bits [3i+2:3i], and lane 0 enters first. After a shift by n, slot k (k < n) holds lane n-1-k.
- R4: A shift with count 0 leaves the register unchanged.
- R5: Counts 5, 6 and 7 behave as a count of 4.
- R6: In a shift by n < 4, input lanes n..3 have no effect on the register.
- R7: A store whose destination bit 0 is set writes the register vector into the state memory at the 4-bit store address. The read port returns entry `mem_raddr` combinationally.
- R8: The latches load the register vector only on a store whose destination bit 1 is set. At all other times they hold their value, including while the register shifts.
- R9: A store with destination 2'b11 writes both the memory and the latches with the same vector in one cycle.
- R10: When a store and a shift are given in the same cycle, the store captures the contents from before the shift.
- R11: A store with destination 2'b00 changes neither the memory nor the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Shift command valid |
| shift_cnt | input | 3 | Number of states to insert (0..4; larger values saturate to 4) |
| shift_din | input | 12 | Four packed 3-bit states; lane 0 in bits [2:0] |
| store_en | input | 1 | Store command valid |
| store_dst | input | 2 | Destination: bit 0 = state memory, bit 1 = latches |
| store_addr | input | 4 | State memory entry written by the store |
| mem_raddr | input | 4 | State memory read address |
| mem_rdata | output | 192 | State memory entry at mem_raddr |
| shreg_q | output | 192 | Shift register contents |
| latch_q | output | 192 | Arithmetic input latch contents |

## Verification
The hardest case to reach is a store and a shift issued in the same cycle. There the pre-shift vector must reach the memory and the latches while the register takes its shifted value. It is hard because the difference only shows when the register holds distinct values in the slots that are moving. The stimulus first fills the register with distinct lane patterns. It then issues combined store-and-shift commands with every destination code. Afterwards it reads back the memory and watches the latches stay frozen through further shifts. A long run of single-slot shifts then pushes all earlier states past the left end, which exercises the discard path.

// File: rtl/lss_pkg.sv
// Package: shared sizes for the multi-lane state shift stage.
// Assumes states are packed slot 0 at the least significant end.
package lss_pkg;
    localparam int SLOT_W    = 3;   // bits per neuron state
    localparam int NSLOTS    = 64;  // state slots in the register
    localparam int IN_LANES  = 4;   // states carried per input word
    localparam int MEM_DEPTH = 16;  // vectors in state memory
    localparam int VEC_W     = SLOT_W * NSLOTS;
    localparam int IN_W      = SLOT_W * IN_LANES;
    localparam int ADDR_W    = $clog2(MEM_DEPTH);
    localparam int CNT_W     = $clog2(IN_LANES + 1);
    localparam int DST_MEM   = 0;   // store destination bit: memory
    localparam int DST_LAT   = 1;   // store destination bit: latches
    typedef logic [1:0] dst_t;
endpackage

// File: rtl/lss_shifter.sv
// Module: lss_shifter
// Left-shifting register of SLOT_W-bit states. A shift by n (0..IN_LANES,
// larger counts saturate) moves each slot up by n and fills slots n-1..0
// from input lanes 0..n-1, lane 0 ending highest (it entered first).
// Assumes the count is sampled only when shift_en is high.
module lss_shifter #(
    parameter int SLOT_W   = lss_pkg::SLOT_W,
    parameter int NSLOTS   = lss_pkg::NSLOTS,
    parameter int IN_LANES = lss_pkg::IN_LANES,
    parameter int CNT_W    = lss_pkg::CNT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [CNT_W-1:0]            shift_cnt,
    input  logic [SLOT_W*IN_LANES-1:0]  din,
    output logic [SLOT_W*NSLOTS-1:0]    q
);
    localparam int VEC_W = SLOT_W * NSLOTS;
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(IN_LANES);

    logic [CNT_W-1:0] eff_cnt;
    logic [VEC_W-1:0] cand [0:IN_LANES];
    logic [VEC_W-1:0] nxt;

    // Saturate oversize counts to the lane limit.
    always_comb eff_cnt = (shift_cnt > MAX_CNT) ? MAX_CNT : shift_cnt;

    assign cand[0] = q;

    // One candidate vector per possible shift amount.
    for (genvar n = 1; n <= IN_LANES; n++) begin : g_amt
        assign cand[n][VEC_W-1:SLOT_W*n] = q[VEC_W-1-SLOT_W*n:0];
        for (genvar j = 0; j < n; j++) begin : g_ins
            assign cand[n][SLOT_W*j +: SLOT_W] = din[SLOT_W*(n-1-j) +: SLOT_W];
        end
    end

    // Pick the candidate for this cycle.
    always_comb nxt = shift_en ? cand[eff_cnt] : q;

    // Register update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> q == '0);
    p_shift_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_cnt == CNT_W'(1)) |=> q[VEC_W-1:SLOT_W] == $past(q[VEC_W-1-SLOT_W:0]));
    p_first_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_cnt == CNT_W'(1)) |=> q[SLOT_W-1:0] == $past(din[SLOT_W-1:0]));
    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en || shift_cnt == '0) |=> $stable(q));
    p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && shift_cnt > MAX_CNT) |=>
        q[VEC_W-1:SLOT_W*IN_LANES] == $past(q[VEC_W-1-SLOT_W*IN_LANES:0]));
endmodule

// File: rtl/lss_state_mem.sv
// Module: lss_state_mem
// Small state-vector memory, one write port, combinational read port.
// Assumes entries are undefined until first written (no reset on storage).
module lss_state_mem #(
    parameter int VEC_W     = lss_pkg::VEC_W,
    parameter int MEM_DEPTH = lss_pkg::MEM_DEPTH,
    parameter int ADDR_W    = lss_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [VEC_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [VEC_W-1:0]  rdata
);
    logic [VEC_W-1:0] mem [0:MEM_DEPTH-1];

    // Write one vector when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read.
    always_comb rdata = mem[raddr];

    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (raddr != $past(waddr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/lss_latch.sv
// Module: lss_latch
// Operand latches for the arithmetic unit: load a vector on command, hold
// otherwise. Assumes load is already qualified by the store destination.
module lss_latch #(
    parameter int VEC_W = lss_pkg::VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d,
    output logic [VEC_W-1:0] q
);
    // Capture or hold the operand vector.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));
endmodule

// File: rtl/lane_shift_stage.sv
// Module: lane_shift_stage (top)
// Input stage of a neuron arithmetic unit: a multi-lane state shift register
// whose contents can be stored to a state memory, the operand latches, or
// both. A store issued with a shift copies the pre-shift contents.
// Assumes commands are single-cycle and take effect at the next clock edge.
module lane_shift_stage
    import lss_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [CNT_W-1:0]    shift_cnt,
    input  logic [IN_W-1:0]     shift_din,
    input  logic                store_en,
    input  logic [1:0]          store_dst,
    input  logic [ADDR_W-1:0]   store_addr,
    input  logic [ADDR_W-1:0]   mem_raddr,
    output logic [VEC_W-1:0]    mem_rdata,
    output logic [VEC_W-1:0]    shreg_q,
    output logic [VEC_W-1:0]    latch_q
);
    dst_t dst;
    logic mem_we;
    logic lat_ld;

    // Decode the store destination into per-target strobes.
    always_comb begin
        dst    = store_dst;
        mem_we = store_en && dst[DST_MEM];
        lat_ld = store_en && dst[DST_LAT];
    end

    lss_shifter #(
        .SLOT_W(SLOT_W), .NSLOTS(NSLOTS), .IN_LANES(IN_LANES), .CNT_W(CNT_W)
    ) shifter_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .shift_cnt(shift_cnt), .din(shift_din), .q(shreg_q)
    );

    lss_state_mem #(
        .VEC_W(VEC_W), .MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)
    ) mem_i (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(store_addr),
        .wdata(shreg_q), .raddr(mem_raddr), .rdata(mem_rdata)
    );

    lss_latch #(.VEC_W(VEC_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .load(lat_ld), .d(shreg_q), .q(latch_q)
    );

    p_pre_shift_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_ld && shift_en) |=> latch_q == $past(shreg_q));
    p_both_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && store_dst == 2'b11) |=>
        (mem_raddr != $past(store_addr)) || (mem_rdata == latch_q));
    p_no_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (store_en && store_dst == 2'b00) |=> $stable(latch_q));
endmodule

// File: tb/lane_shift_stage_tb_top.sv
// Scoreboard bench: the driver computes expected register/latch vectors and
// queues them; the monitor compares them one clock after each command.
module lane_shift_stage_tb_top;
    localparam int VW = 192;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          shift_en;
    logic [2:0]    shift_cnt;
    logic [11:0]   shift_din;
    logic          store_en;
    logic [1:0]    store_dst;
    logic [3:0]    store_addr;
    logic [3:0]    mem_raddr;
    logic [VW-1:0] mem_rdata;
    logic [VW-1:0] shreg_q;
    logic [VW-1:0] latch_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [VW-1:0] sh;
        logic [VW-1:0] lt;
        string         tag;
    } exp_t;
    exp_t sb [$];

    logic [VW-1:0] sh_m;
    logic [VW-1:0] lt_m;
    logic [VW-1:0] mem_m [0:15];

    always #10 clk = ~clk;

    lane_shift_stage dut_i (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_cnt(shift_cnt),
        .shift_din(shift_din), .store_en(store_en), .store_dst(store_dst),
        .store_addr(store_addr), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .shreg_q(shreg_q), .latch_q(latch_q)
    );

    task automatic cmp(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare one queued item after each clock edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(shreg_q, e.sh, {e.tag, " register"});
            cmp(latch_q, e.lt, {e.tag, " latches"});
        end
    end

    // Driver: apply one command, update the model, queue the expectation.
    task automatic step(input logic se, input logic [2:0] cnt, input logic [11:0] d,
                        input logic ste, input logic [1:0] dst, input logic [3:0] addr,
                        input string tag);
        exp_t e;
        int n;
        @(negedge clk);
        shift_en = se; shift_cnt = cnt; shift_din = d;
        store_en = ste; store_dst = dst; store_addr = addr;
        if (ste && dst[0]) mem_m[addr] = sh_m;   // R10: store sees pre-shift value
        if (ste && dst[1]) lt_m = sh_m;
        n = (cnt > 3'd4) ? 4 : int'(cnt);
        if (se) for (int i = 0; i < n; i++) sh_m = {sh_m[VW-4:0], d[3*i +: 3]};
        e.sh = sh_m; e.lt = lt_m; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, 12'h000, 1'b0, 2'b00, 4'd0, tag);
    endtask

    task automatic mem_check(input logic [3:0] a, input string tag);
        idle(tag);
        mem_raddr = a;
        #1;
        cmp(mem_rdata, mem_m[a], {tag, " memory"});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] lf;
        rst_n = 1'b0; shift_en = 1'b0; shift_cnt = '0; shift_din = '0;
        store_en = 1'b0; store_dst = '0; store_addr = '0; mem_raddr = '0;
        sh_m = '0; lt_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cmp(shreg_q, '0, "R1 reset register");
        cmp(latch_q, '0, "R1 reset latches");

        step(1'b1, 3'd4, 12'o4321, 1'b0, 2'b00, 4'd0, "R3 order count4");
        step(1'b1, 3'd0, 12'o7777, 1'b0, 2'b00, 4'd0, "R4 count zero");
        step(1'b1, 3'd2, 12'o7765, 1'b0, 2'b00, 4'd0, "R6 upper lanes ignored");
        step(1'b1, 3'd1, 12'o7773, 1'b0, 2'b00, 4'd0, "R6 count1");
        step(1'b1, 3'd7, 12'o1234, 1'b0, 2'b00, 4'd0, "R5 count7");
        step(1'b1, 3'd5, 12'o5670, 1'b0, 2'b00, 4'd0, "R5 count5");
        step(1'b1, 3'd3, 12'o0456, 1'b0, 2'b00, 4'd0, "R2 count3");
        step(1'b0, 3'd4, 12'o7777, 1'b1, 2'b01, 4'd3, "R7 store memory");
        mem_check(4'd3, "R7 read back");
        step(1'b0, 3'd0, 12'o0000, 1'b1, 2'b10, 4'd0, "R8 store latches");
        step(1'b1, 3'd4, 12'o3210, 1'b0, 2'b00, 4'd0, "R8 latches hold while shifting");
        step(1'b1, 3'd2, 12'o0076, 1'b1, 2'b11, 4'd15, "R9 R10 both with shift");
        mem_check(4'd15, "R9 read back");
        step(1'b1, 3'd1, 12'o0005, 1'b1, 2'b01, 4'd5, "R10 memory with shift");
        step(1'b1, 3'd4, 12'o6543, 1'b1, 2'b00, 4'd5, "R11 no destination");
        mem_check(4'd5, "R11 memory untouched");
        step(1'b1, 3'd3, 12'o0123, 1'b1, 2'b10, 4'd9, "R10 latches with shift");
        mem_check(4'd9, "R11 latch-only store");  // entry 9 still unwritten (X)

        for (int k = 0; k < 70; k++)
            step(1'b1, 3'd1, 12'(k % 8), 1'b0, 2'b00, 4'd0, "R2 discard at left end");

        lf = 12'hace;
        for (int k = 0; k < 60; k++) begin
            lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
            step(lf[0], lf[3:1], lf, lf[4], lf[6:5], lf[10:7], "R2 R3 mixed");
        end
        for (int a = 0; a < 16; a++)
            if (mem_m[a] !== 'x) mem_check(4'(a), "R7 mixed read back");
        idle("R8 final");
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule